// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits that walk a memory access through a four-beat burst. A burst starts when the controller pulses `load`. The block then copies the low bits of the external address as the first beat, and it samples the ordering selector at the same time. After that, each clock with the active-low step input `step_n` held low moves the output to the next beat. The order is either interleaved (the start value XORed with the beat number) or linear (the start value plus the beat number, modulo four).

When `step_n` is high the burst is paused and the same offset is presented again. A step taken from the fourth beat returns the burst to its first beat, so the sequence repeats rather than ending. A registered flag marks the fourth beat in either order. A beat index is kept apart from the presented offset, so this flag does not depend on which order is in use. The higher address bits and all bus control are handled outside the block.

The block has no data stream, so every pin is a plain level-sensitive control or status signal and no handshake is involved.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `offset` to 00 and `last_beat` to 0.
- R2: After an edge with `load` high, `offset` equals the `start_addr` presented at that edge and `last_beat` is 0.
- R3: With `order_lin` = 0 sampled at load, successive steps from start S give offsets S, S^01, S^10, S^11.
- R4: With `order_lin` = 1 sampled at load, successive steps from start S give offsets S, S+1, S+2, S+3, all modulo 4.
- R5: An edge with `load` low and `step_n` high leaves `offset` and `last_beat` unchanged.
- R6: A step taken on the fourth beat returns `offset` to the loaded start value and clears `last_beat`.
- R7: `last_beat` is 1 exactly while the burst sits on its fourth beat (beat index 3), in both orders.
- R8: `order_lin` is only sampled on a load edge. A change to it during a burst does not alter that burst's sequence.
- R9: When `load` and a step (`step_n` low) occur on the same edge, the load wins and `offset` equals the new start with `last_beat` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Starts a new burst from `start_addr` |
| start_addr | input | 2 | Low address bits that give the first beat |
| step_n | input | 1 | Active-low advance; high pauses the burst |
| order_lin | input | 1 | Ordering selector sampled at load: 0 interleaved, 1 linear |
| offset | output | 2 | Current burst offset |
| last_beat | output | 1 | Registered marker of the fourth beat |

## Verification
The in-RTL assertions check the following on every clock:
- the load captures the start value;
- a paused cycle changes nothing;
- each step moves by the correct amount in either order;
- the flag clears on wrap;
- the flag always agrees with the beat index.

Some behaviours need the bench's scenarios instead, because they span a whole burst. These are the full four-beat sequences for every start value in both orders, the return to the exact loaded start, and the fact that toggling the order input mid-burst leaves the sequence alone. The bench's reference model tracks start, beat and order on its own and compares both outputs on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_XOR = 1'b0,
    ORDER_LIN = 1'b1
  } order_t;
endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step_n,
  output logic [OFS_W-1:0] beat,
  output logic             last
);
  localparam logic [OFS_W-1:0] LAST_IDX = '1;

  logic [OFS_W-1:0] beat_q;
  logic [OFS_W-1:0] beat_inc;
  logic             last_q;

  assign beat_inc = beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      beat_q <= '0;
      last_q <= 1'b0;
    end else if (!step_n) begin
      beat_q <= beat_inc;
      last_q <= (beat_inc == LAST_IDX);
    end
  end

  assign beat = beat_q;
  assign last = last_q;

  // R7
  last_matches_idx_chk: assert property (@(posedge clk) disable iff (rst)
    last_q == (beat_q == LAST_IDX));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] base,
  input  logic [OFS_W-1:0] beat,
  input  order_t           order,
  output logic [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] ofs_xor;
  logic [OFS_W-1:0] ofs_lin;

  genvar g;
  generate
    for (g = 0; g < OFS_W; g++) begin : g_xor_bit
      assign ofs_xor[g] = base[g] ^ beat[g];
    end
  endgenerate

  assign ofs_lin = base + beat;

  always_comb begin
    unique case (order)
      ORDER_LIN: ofs = ofs_lin;
      default:   ofs = ofs_xor;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFS_W-1:0] start_addr,
  input  logic             step_n,
  input  logic             order_lin,
  output logic [OFS_W-1:0] offset,
  output logic             last_beat
);
  logic [OFS_W-1:0] base_q;
  order_t           order_q;
  logic [OFS_W-1:0] beat;
  logic             last;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      order_q <= ORDER_XOR;
    end else if (load) begin
      base_q  <= start_addr;
      order_q <= order_t'(order_lin);
    end
  end

  bseq_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step_n (step_n),
    .beat   (beat),
    .last   (last)
  );

  bseq_order_map #(.OFS_W(OFS_W)) u_map (
    .base  (base_q),
    .beat  (beat),
    .order (order_q),
    .ofs   (offset)
  );

  assign last_beat = last;

  // R2, R9
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (offset == $past(start_addr)) && !last_beat);

  // R5
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step_n) |=> $stable(offset) && $stable(last_beat));

  // R4
  lin_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_n && order_q == ORDER_LIN) |=>
      offset == OFS_W'($past(offset) + 1'b1));

  // R3
  xor_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_n && order_q == ORDER_XOR) |=>
      (offset ^ $past(offset)) == (OFS_W'($past(beat) + 1'b1) ^ $past(beat)));

  // R6
  wrap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !load && !step_n) |=> !last_beat);
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [1:0] start_addr = 2'b00;
  logic       step_n = 1'b1;
  logic       order_lin = 1'b0;
  logic [1:0] offset;
  logic       last_beat;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_start = 0;
  int m_beat = 0;
  bit m_lin = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .start_addr (start_addr),
    .step_n     (step_n),
    .order_lin  (order_lin),
    .offset     (offset),
    .last_beat  (last_beat)
  );

  function automatic int exp_ofs();
    if (m_lin) return (m_start + m_beat) % 4;
    return m_start ^ m_beat;
  endfunction

  task automatic compare(input string tag);
    int eo;
    bit el;
    eo = exp_ofs();
    el = (m_beat == 3);
    n_checks++;
    if (int'(offset) != eo || last_beat != el) begin
      n_fail++;
      $display("FAIL %s: offset=%0d last=%0d expected offset=%0d last=%0d",
               tag, offset, last_beat, eo, el);
    end
  endtask

  task automatic cycle(input bit ld, input int sa, input bit sn, input bit lin,
                       input string tag);
    load = ld;
    start_addr = 2'(sa);
    step_n = sn;
    order_lin = lin;
    @(posedge clk);
    if (ld) begin
      m_start = sa;
      m_beat = 0;
      m_lin = lin;
    end else if (!sn) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    compare("R1");
    rst = 1'b0;
    cycle(0, 0, 1, 0, "R1");

    // R3 interleaved from 10, then R6 wrap
    cycle(1, 2, 1, 0, "R2");
    cycle(0, 0, 0, 0, "R3");
    cycle(0, 0, 0, 0, "R3");
    cycle(0, 0, 0, 0, "R7");
    cycle(0, 0, 0, 0, "R6");

    // R4 linear from 11
    cycle(1, 3, 1, 1, "R2");
    cycle(0, 0, 0, 1, "R4");
    cycle(0, 0, 0, 1, "R4");
    cycle(0, 0, 0, 1, "R7");
    cycle(0, 0, 0, 1, "R6");

    // R5 pause with outputs held, including on the last beat
    cycle(1, 1, 1, 1, "R2");
    cycle(0, 0, 0, 1, "R4");
    cycle(0, 3, 1, 0, "R5");
    cycle(0, 2, 1, 1, "R5");
    cycle(0, 0, 0, 1, "R4");
    cycle(0, 0, 0, 1, "R7");
    cycle(0, 0, 1, 1, "R5");
    cycle(0, 0, 0, 1, "R6");

    // R8 order input toggles mid-burst
    cycle(1, 1, 1, 0, "R2");
    cycle(0, 0, 0, 1, "R8");
    cycle(0, 0, 0, 1, "R8");
    cycle(0, 0, 0, 1, "R8");
    cycle(0, 0, 0, 0, "R8");

    // R9 load together with step
    cycle(0, 0, 0, 0, "R3");
    cycle(1, 3, 0, 1, "R9");
    cycle(0, 0, 0, 1, "R4");
    cycle(1, 2, 0, 0, "R9");

    // every start in both orders, two passes each
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        cycle(1, s, 1, bit'(lin), "R2");
        for (int k = 0; k < 8; k++)
          cycle(0, 0, 0, bit'(lin), lin ? "R4" : "R3");
      end
    end

    // R1 reset mid-burst
    cycle(1, 3, 1, 1, "R2");
    cycle(0, 0, 0, 1, "R4");
    rst = 1'b1;
    @(posedge clk);
    m_start = 0;
    m_beat = 0;
    m_lin = 1'b0;
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    cycle(0, 0, 0, 0, "R3");

    done = 1'b1;
  end

  initial begin
    int cnt;
    cnt = 0;
    while (!done && cnt < 5000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule